// File: doc/BRIEF.md
# Paged Program Counter with Interrupt Vectors

This block holds the 14-bit fetch address for a 16K-word instruction store. The store is divided into eight pages of 2048 words, so the address has a 3-bit page field above an 11-bit offset. On every instruction boundary marked by the fetch enable, the counter chooses its next value. It can step forward, take a far transfer, take a near transfer, skip, return, or enter an interrupt. A far transfer is a jump or a call. It uses a page value that software has written earlier into a separate page holder, and it takes only the 11-bit offset from the instruction. A near transfer is a taken conditional branch. It keeps the current page and replaces only the offset.

Reset starts execution at word 0. Five interrupt request lines each have a fixed vector. When several lines are active together, the lowest-numbered line wins. An interrupt entry, like a call, asks the surrounding stack to push a return address. The counter itself does not hold the stack. A return reloads the counter from the stack top that the stack presents. Decoding, interrupt masking and the memory lie outside the block.

Top module: `pgpc_core`

## Requirements
- R1: After reset the PC is 0x0000 and the page holder is 0, so a jump issued before any page write lands in page 0.
- R2: While fetch_en is 0 the PC keeps its value and push_req stays 0, whatever the other controls and interrupt lines do.
- R3: A fetch with no control active adds 1 to the full 14-bit PC. This carries across page boundaries, and 0x3FFF steps to 0x0000.
- R4: A jump loads {page holder, tgt_off}. A page write in the same cycle as the jump does not affect that jump; it takes effect from the next cycle.
- R5: A call loads {page holder, tgt_off} and, in the same cycle, raises push_req with push_addr equal to PC+1 modulo 2^14.
- R6: A taken branch loads {current PC page, tgt_off}.
- R7: A skip adds 2 to the 11-bit offset only. The sum wraps inside the current page, so offset 0x7FE goes to offset 0x000 of the same page.
- R8: A return loads stack_top into the PC and leaves push_req at 0.
- R9: An interrupt on line 0, 1, 2, 3 or 4 loads vector 0x0004, 0x0008, 0x000C, 0x0014 or 0x0020 respectively.
- R10: Line 0 has the highest priority and line 4 the lowest. Only the winning line is taken. It overrides every instruction control in that cycle, and it raises push_req with push_addr equal to the current PC.
- R11: When several instruction controls are active together, the order from highest to lowest is return, call, jump, branch, skip.
- R12: The page holder changes only on a cycle with page_we at 1, and it keeps the written value until the next write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_en | input | 1 | Instruction boundary; the PC may change only when it is 1 |
| op_jump | input | 1 | Unconditional jump |
| op_call | input | 1 | Subroutine call |
| op_branch | input | 1 | Taken conditional branch within the page |
| op_skip | input | 1 | Taken skip of the next word |
| op_ret | input | 1 | Return from subroutine or interrupt |
| tgt_off | input | 11 | In-page target offset from the instruction |
| page_we | input | 1 | Write strobe for the page holder |
| page_wdata | input | 3 | Page value to write |
| irq_req | input | 5 | Interrupt requests; bit 0 has the highest priority |
| stack_top | input | 14 | Return address offered by the stack |
| pc | output | 14 | Current fetch address |
| push_req | output | 1 | Asks the stack to push push_addr this cycle |
| push_addr | output | 14 | Return address to push |

## Verification
Two pairs of functions can land in the same fetch cycle. The first is an interrupt and a call. The bench raises several request lines together with a call and checks three things: the PC lands on the vector of the lowest-numbered line, only one push is requested, and the pushed value is the current PC rather than PC+1. The second is a page write and a jump. The bench issues both in one cycle and expects the old page, then sends a later jump and expects the new page.

// File: rtl/pgpc_pkg.sv
package pgpc_pkg;

  localparam int PC_W_DEF  = 14;
  localparam int OFF_W_DEF = 11;
  localparam int N_IRQ_DEF = 5;

  typedef enum logic [2:0] {
    NX_HOLD,
    NX_INC,
    NX_SKIP,
    NX_NEAR,
    NX_FAR,
    NX_RET,
    NX_VEC
  } nx_sel_e;

  // fixed entry address per request line, line 0 first
  function automatic logic [31:0] irq_vector(input int unsigned idx);
    logic [31:0] v;
    case (idx)
      0:       v = 32'h0004;
      1:       v = 32'h0008;
      2:       v = 32'h000C;
      3:       v = 32'h0014;
      4:       v = 32'h0020;
      default: v = 32'h0000;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/pgpc_rst_sync.sv
module pgpc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/pgpc_page_reg.sv
module pgpc_page_reg #(
  parameter int PG_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [PG_W-1:0] wr_data,
  output logic [PG_W-1:0] page_q
);

  logic [PG_W-1:0] page_d;

  always_comb begin
    page_d = page_q;
    if (wr_en) begin
      page_d = wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q <= '0;
    end else if (wr_en) begin
      page_q <= page_d;
    end
  end

  // page holder only moves on a write strobe
  assert_pgreg_hold_R12 : assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(page_q));

endmodule

// File: rtl/pgpc_irq_arb.sv
module pgpc_irq_arb
  import pgpc_pkg::*;
#(
  parameter int N_IRQ = 5,
  parameter int PC_W  = 14
) (
  input  logic [N_IRQ-1:0] req,
  output logic [N_IRQ-1:0] grant,
  output logic             any,
  output logic [PC_W-1:0]  vec
);

  logic [PC_W-1:0] vec_tab [N_IRQ];

  for (genvar g = 0; g < N_IRQ; g++) begin : g_vec
    localparam logic [31:0] VEC_FULL = irq_vector(g);
    assign vec_tab[g] = VEC_FULL[PC_W-1:0];
  end

  // scan from the lowest priority upward so that line 0 wins last
  always_comb begin
    grant = '0;
    for (int i = N_IRQ - 1; i >= 0; i--) begin
      if (req[i]) begin
        grant    = '0;
        grant[i] = 1'b1;
      end
    end
  end

  always_comb begin
    vec = '0;
    for (int i = 0; i < N_IRQ; i++) begin
      if (grant[i]) begin
        vec = vec | vec_tab[i];
      end
    end
  end

  assign any = |req;

endmodule

// File: rtl/pgpc_next_sel.sv
module pgpc_next_sel
  import pgpc_pkg::*;
(
  input  logic    fetch_en,
  input  logic    irq_any,
  input  logic    op_ret,
  input  logic    op_call,
  input  logic    op_jump,
  input  logic    op_branch,
  input  logic    op_skip,
  output nx_sel_e sel,
  output logic    push_req,
  output logic    push_is_irq
);

  always_comb begin
    sel         = NX_HOLD;
    push_req    = 1'b0;
    push_is_irq = 1'b0;
    if (fetch_en) begin
      if (irq_any) begin
        sel         = NX_VEC;
        push_req    = 1'b1;
        push_is_irq = 1'b1;
      end else if (op_ret) begin
        sel = NX_RET;
      end else if (op_call) begin
        sel      = NX_FAR;
        push_req = 1'b1;
      end else if (op_jump) begin
        sel = NX_FAR;
      end else if (op_branch) begin
        sel = NX_NEAR;
      end else if (op_skip) begin
        sel = NX_SKIP;
      end else begin
        sel = NX_INC;
      end
    end
  end

endmodule

// File: rtl/pgpc_core.sv
module pgpc_core
  import pgpc_pkg::*;
#(
  parameter int PC_W  = PC_W_DEF,
  parameter int OFF_W = OFF_W_DEF,
  parameter int N_IRQ = N_IRQ_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_en,
  input  logic              op_jump,
  input  logic              op_call,
  input  logic              op_branch,
  input  logic              op_skip,
  input  logic              op_ret,
  input  logic [OFF_W-1:0]  tgt_off,
  input  logic              page_we,
  input  logic [PC_W-OFF_W-1:0] page_wdata,
  input  logic [N_IRQ-1:0]  irq_req,
  input  logic [PC_W-1:0]   stack_top,
  output logic [PC_W-1:0]   pc,
  output logic              push_req,
  output logic [PC_W-1:0]   push_addr
);

  localparam int PG_W = PC_W - OFF_W;

  logic             rst_sync_n;
  logic [PG_W-1:0]  page_q;
  logic [N_IRQ-1:0] grant;
  logic             irq_any;
  logic [PC_W-1:0]  irq_vec;
  nx_sel_e          sel;
  logic             push_is_irq;

  logic [PC_W-1:0]  pc_q;
  logic [PC_W-1:0]  pc_d;
  logic [PC_W-1:0]  pc_inc;
  logic [PC_W-1:0]  pc_skip;
  logic [PC_W-1:0]  pc_near;
  logic [PC_W-1:0]  pc_far;
  logic [OFF_W-1:0] off_skip;

  pgpc_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  pgpc_page_reg #(.PG_W(PG_W)) u_page (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (page_we),
    .wr_data (page_wdata),
    .page_q  (page_q)
  );

  pgpc_irq_arb #(.N_IRQ(N_IRQ), .PC_W(PC_W)) u_arb (
    .req   (irq_req),
    .grant (grant),
    .any   (irq_any),
    .vec   (irq_vec)
  );

  pgpc_next_sel u_sel (
    .fetch_en    (fetch_en),
    .irq_any     (irq_any),
    .op_ret      (op_ret),
    .op_call     (op_call),
    .op_jump     (op_jump),
    .op_branch   (op_branch),
    .op_skip     (op_skip),
    .sel         (sel),
    .push_req    (push_req),
    .push_is_irq (push_is_irq)
  );

  // candidate addresses
  always_comb begin
    pc_inc   = pc_q + PC_W'(1);
    off_skip = pc_q[OFF_W-1:0] + OFF_W'(2);
    pc_skip  = {pc_q[PC_W-1:OFF_W], off_skip};
    pc_near  = {pc_q[PC_W-1:OFF_W], tgt_off};
    pc_far   = {page_q, tgt_off};
  end

  always_comb begin
    case (sel)
      NX_INC:  pc_d = pc_inc;
      NX_SKIP: pc_d = pc_skip;
      NX_NEAR: pc_d = pc_near;
      NX_FAR:  pc_d = pc_far;
      NX_RET:  pc_d = stack_top;
      NX_VEC:  pc_d = irq_vec;
      default: pc_d = pc_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      pc_q <= '0;
    end else if (fetch_en) begin
      pc_q <= pc_d;
    end
  end

  assign push_addr = push_is_irq ? pc_q : pc_inc;
  assign pc        = pc_q;

  // R2: no movement without a fetch boundary
  assert_hold_R2 : assert property (@(posedge clk) disable iff (!rst_sync_n)
    !fetch_en |=> $stable(pc_q));

  assert_nopush_R2 : assert property (@(posedge clk) disable iff (!rst_sync_n)
    !fetch_en |-> !push_req);

  // R6: a lone branch never changes the page field
  assert_near_page_R6 : assert property (@(posedge clk) disable iff (!rst_sync_n)
    (fetch_en && op_branch && !op_ret && !op_call && !op_jump && (irq_req == '0))
      |=> (pc_q[PC_W-1:OFF_W] == $past(pc_q[PC_W-1:OFF_W])));

  // R7: a lone skip stays in its page
  assert_skip_page_R7 : assert property (@(posedge clk) disable iff (!rst_sync_n)
    (fetch_en && op_skip && !op_branch && !op_ret && !op_call && !op_jump && (irq_req == '0))
      |=> (pc_q[PC_W-1:OFF_W] == $past(pc_q[PC_W-1:OFF_W])));

  // R8: a return reloads from the stack without pushing
  assert_ret_load_R8 : assert property (@(posedge clk) disable iff (!rst_sync_n)
    (fetch_en && op_ret && (irq_req == '0)) |=> (pc_q == $past(stack_top)));

  assert_ret_nopush_R8 : assert property (@(posedge clk) disable iff (!rst_sync_n)
    (fetch_en && op_ret && (irq_req == '0)) |-> !push_req);

  // R9: line 0 always lands on its entry
  assert_vec0_R9 : assert property (@(posedge clk) disable iff (!rst_sync_n)
    (fetch_en && irq_req[0]) |=> (pc_q == PC_W'(14'h0004)));

  // R10: single winner, and an interrupt always pushes the current PC
  assert_grant_onehot_R10 : assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0(grant));

  assert_irq_push_R10 : assert property (@(posedge clk) disable iff (!rst_sync_n)
    (fetch_en && (irq_req != '0)) |-> (push_req && (push_addr == pc_q)));

endmodule

// File: tb/pgpc_core_bench.sv
module pgpc_core_bench;

  logic        clk;
  logic        rst_n;
  logic        fetch_en;
  logic        op_jump, op_call, op_branch, op_skip, op_ret;
  logic [10:0] tgt_off;
  logic        page_we;
  logic [2:0]  page_wdata;
  logic [4:0]  irq_req;
  logic [13:0] stack_top;
  logic [13:0] pc;
  logic        push_req;
  logic [13:0] push_addr;

  pgpc_core u_pgpc_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .fetch_en   (fetch_en),
    .op_jump    (op_jump),
    .op_call    (op_call),
    .op_branch  (op_branch),
    .op_skip    (op_skip),
    .op_ret     (op_ret),
    .tgt_off    (tgt_off),
    .page_we    (page_we),
    .page_wdata (page_wdata),
    .irq_req    (irq_req),
    .stack_top  (stack_top),
    .pc         (pc),
    .push_req   (push_req),
    .push_addr  (push_addr)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  typedef struct {
    logic        exp_push;
    logic [13:0] exp_paddr;
    logic [13:0] exp_pc;
    string       tag;
  } item_t;

  item_t exp_q[$];
  int    n_checks = 0;
  int    n_fails  = 0;
  bit    finished = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [13:0] act, input logic [13:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s: actual 0x%04h expected 0x%04h", tag, what, act, exp);
    end
  endtask

  // fetch_en, jump, call, branch, skip, ret, offset, page write, page data,
  // requests, stack top, then the expected push, push address and next PC
  task automatic step(input logic fe, input logic j, input logic c, input logic b,
                      input logic s, input logic r, input logic [10:0] off,
                      input logic pwe, input logic [2:0] pwd, input logic [4:0] irq,
                      input logic [13:0] stk, input logic ep, input logic [13:0] epa,
                      input logic [13:0] epc, input string tag);
    item_t it;
    @(negedge clk);
    fetch_en = fe; op_jump = j; op_call = c; op_branch = b; op_skip = s; op_ret = r;
    tgt_off = off; page_we = pwe; page_wdata = pwd; irq_req = irq; stack_top = stk;
    it.exp_push = ep; it.exp_paddr = epa; it.exp_pc = epc; it.tag = tag;
    exp_q.push_back(it);
  endtask

  // monitor: push outputs before the edge, PC after it
  initial begin
    forever begin
      @(negedge clk);
      #4;
      if (exp_q.size() > 0) begin
        item_t it;
        it = exp_q.pop_front();
        check(push_req == it.exp_push, it.tag, "push_req",
              {13'b0, push_req}, {13'b0, it.exp_push});
        if (it.exp_push) begin
          check(push_addr == it.exp_paddr, it.tag, "push_addr", push_addr, it.exp_paddr);
        end
        @(posedge clk);
        #4;
        check(pc == it.exp_pc, it.tag, "pc", pc, it.exp_pc);
      end
    end
  end

  initial begin
    #(20 * 200000);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; fetch_en = 0; op_jump = 0; op_call = 0; op_branch = 0; op_skip = 0;
    op_ret = 0; tgt_off = '0; page_we = 0; page_wdata = '0; irq_req = '0; stack_top = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(pc == 14'h0000, "R1", "reset pc", pc, 14'h0000);
    check(push_req == 1'b0, "R1", "reset push", {13'b0, push_req}, 14'h0000);

    //    fe j c b s r  off     we d  irq       stk       ep  epa       epc
    step(1,0,0,0,0,0, 11'h000, 0,3'd0,5'b00000,14'h0000, 0,14'h0000,14'h0001,"R3_inc");
    step(0,0,0,0,0,0, 11'h000, 0,3'd0,5'b00000,14'h0000, 0,14'h0000,14'h0001,"R2_hold");
    step(1,1,0,0,0,0, 11'h123, 0,3'd0,5'b00000,14'h0000, 0,14'h0000,14'h0123,"R1_page0_R4");
    step(0,0,0,0,0,0, 11'h000, 1,3'd5,5'b00000,14'h0000, 0,14'h0000,14'h0123,"R12_write");
    step(1,1,0,0,0,0, 11'h7FF, 1,3'd2,5'b00000,14'h0000, 0,14'h0000,14'h2FFF,"R4_same_cycle");
    step(1,0,0,0,0,0, 11'h000, 0,3'd0,5'b00000,14'h0000, 0,14'h0000,14'h3000,"R3_cross");
    step(1,1,0,0,0,0, 11'h000, 0,3'd0,5'b00000,14'h0000, 0,14'h0000,14'h1000,"R12_kept");
    step(1,0,1,0,0,0, 11'h010, 0,3'd0,5'b00000,14'h0000, 1,14'h1001,14'h1010,"R5_call");
    step(1,0,0,1,0,0, 11'h7FE, 0,3'd0,5'b00000,14'h0000, 0,14'h0000,14'h17FE,"R6_branch");
    step(1,0,0,0,1,0, 11'h000, 0,3'd0,5'b00000,14'h0000, 0,14'h0000,14'h1000,"R7_wrap");
    step(1,0,0,0,1,0, 11'h000, 0,3'd0,5'b00000,14'h0000, 0,14'h0000,14'h1002,"R7_skip");
    step(1,0,0,0,0,1, 11'h000, 0,3'd0,5'b00000,14'h1234, 0,14'h0000,14'h1234,"R8_ret");
    step(1,0,0,0,0,0, 11'h000, 0,3'd0,5'b10000,14'h0000, 1,14'h1234,14'h0020,"R9_line4");
    step(1,0,0,0,0,0, 11'h000, 0,3'd0,5'b01000,14'h0000, 1,14'h0020,14'h0014,"R9_line3");
    step(1,0,0,0,0,0, 11'h000, 0,3'd0,5'b00100,14'h0000, 1,14'h0014,14'h000C,"R9_line2");
    step(1,0,0,0,0,0, 11'h000, 0,3'd0,5'b00010,14'h0000, 1,14'h000C,14'h0008,"R9_line1");
    step(1,0,0,0,0,0, 11'h000, 0,3'd0,5'b00001,14'h0000, 1,14'h0008,14'h0004,"R9_line0");
    step(1,0,1,0,0,0, 11'h300, 0,3'd0,5'b10110,14'h0000, 1,14'h0004,14'h0008,"R10_irq_call");
    step(0,1,1,1,1,1, 11'h300, 0,3'd0,5'b11111,14'h0ABC, 0,14'h0000,14'h0008,"R2_irq_blocked");
    step(1,1,1,1,0,0, 11'h055, 0,3'd0,5'b00000,14'h0000, 1,14'h0009,14'h1055,"R11_call_wins");
    step(1,1,0,1,0,0, 11'h001, 0,3'd0,5'b00000,14'h0000, 0,14'h0000,14'h1001,"R11_jump_wins");
    step(1,0,1,0,0,1, 11'h200, 0,3'd0,5'b00000,14'h3FFF, 0,14'h0000,14'h3FFF,"R11_ret_wins");
    step(1,0,0,0,0,0, 11'h000, 0,3'd0,5'b00000,14'h0000, 0,14'h0000,14'h0000,"R3_wrap");
    step(1,0,0,1,1,0, 11'h100, 0,3'd0,5'b00000,14'h0000, 0,14'h0000,14'h0100,"R11_branch_wins");
    step(0,0,0,0,0,0, 11'h000, 0,3'd0,5'b00000,14'h0000, 0,14'h0000,14'h0100,"R2_idle");

    repeat (3) @(negedge clk);
    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    $finish;
  end

endmodule